// File: doc/BRIEF.md
# Flash Status and Interrupt Controller

This block sits beside a flash memory controller. It turns single-cycle event pulses from that controller into sticky status flags, and it produces one maskable interrupt request for an external interrupt controller. The events are: program finished, erase finished, operation aborted, verify failed, protection violation, command sequence error, corrected single-bit read and uncorrectable double-bit read. The controller's busy level is also an input.

Software reaches the block through a small register port. One address returns the status flags, and writing ones to that address clears the matching flags. The other address holds the per-source interrupt enable mask, and software can both read and write it.

Abort and verify failures can occur while an operation is still running. Their interrupt is deferred until busy drops, but their flag is recorded at once. The interrupt is a one-cycle pulse. Each new qualifying event produces a new pulse, including an event whose flag is already set.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all status flags read 0, the enable mask reads 0 and `irq` is 0.
- R2: Each event sets its status flag, which can be read at address 0 from the cycle after the event. The bit positions are: 0 program done, 1 erase done, 2 abort, 3 verify, 4 protection, 5 sequence, 6 single-bit, 7 double-bit.
- R3: A falling edge of `busy` sets flag bit 0 if `op_is_erase` was 0 on the cycle `busy` rose. It sets flag bit 1 if `op_is_erase` was 1 on that cycle.
- R4: Writing to address 0 clears exactly the flag bits written as 1. Bits written as 0 are left unchanged. No flag clears in any other way.
- R5: A clear and a new event for the same flag in the same cycle leave that flag set.
- R6: `irq` is high for exactly the one cycle after a qualifying event whose enable bit is 1. An event whose enable bit is 0 still sets its flag but produces no pulse. The enable bit positions at address 1 are: 0 end of busy, 1 abort, 2 verify, 3 protection, 4 sequence, 5 single-bit, 6 double-bit.
- R7: An abort or verify event that arrives while `busy` is 1 gives no pulse while busy lasts. It gives one pulse in the cycle after `busy` falls, but only if its enable bit is set on the falling cycle. The same event with `busy` at 0 gives a pulse at once.
- R8: An event produces a pulse even when its flag is still set from an earlier event.
- R9: Several qualifying events in the same cycle produce a single one-cycle pulse.
- R10: Writing the enable mask while flags are set does not by itself produce a pulse.
- R11: Reading address 1 returns the enable mask in bits 6:0, with bit 7 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Flash operation in progress |
| op_is_erase | input | 1 | Operation type, sampled when busy rises (1 = erase) |
| ev_abort | input | 1 | Operation abort event pulse |
| ev_verify | input | 1 | Verify failure event pulse |
| ev_prot | input | 1 | Protection violation event pulse |
| ev_seq | input | 1 | Command sequence error event pulse |
| ev_sbe | input | 1 | Corrected single-bit read event pulse |
| ev_dbe | input | 1 | Double-bit read error event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 status clear, 1 enable mask |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read address: 0 status, 1 enable mask |
| rd_data | output | DATA_W | Read data for rd_addr |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The hardest situation to reach is a deferred abort or verify event whose enable bit changes before busy falls. A pulse in that case depends on the enable value on the falling cycle, not on its value when the event arrived. The directed part of the stimulus holds busy high, injects an abort, clears the mask and then drops busy, so that the request must be suppressed. It also covers a verify that arrives during busy and is released on the fall. The random part toggles busy in long runs, fires events and rewrites the mask at random cycles, so deferred events regularly meet mask writes and simultaneous clears.

// File: rtl/flash_irq_pkg.sv
// Shared constants for the flash status and interrupt controller.
// Assumes the flag and source positions below are fixed by software.
package flash_irq_pkg;
    localparam int FLAG_W  = 8;
    localparam int NUM_SRC = 7;
    localparam int NUM_HELD = 2;

    // Status flag positions
    localparam int FLG_PROG   = 0;
    localparam int FLG_ERASE  = 1;
    localparam int FLG_ABORT  = 2;
    localparam int FLG_VERIFY = 3;
    localparam int FLG_PROT   = 4;
    localparam int FLG_SEQ    = 5;
    localparam int FLG_SBE    = 6;
    localparam int FLG_DBE    = 7;

    // Interrupt source (enable bit) positions
    localparam int SRC_DONE   = 0;
    localparam int SRC_ABORT  = 1;
    localparam int SRC_VERIFY = 2;
    localparam int SRC_PROT   = 3;
    localparam int SRC_SEQ    = 4;
    localparam int SRC_SBE    = 5;
    localparam int SRC_DBE    = 6;
endpackage

// File: rtl/busy_phase_tracker.sv
// Tracks the busy level of the flash controller.
// Reports the cycle in which busy falls and the operation type latched at its rise.
// Assumes op_is_erase is valid on the cycle busy rises.
module busy_phase_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic op_is_erase,
    output logic busy_fall,
    output logic end_is_erase
);
    logic busy_q;
    logic op_q;

    // Register busy and capture the operation type at the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            op_q   <= 1'b0;
        end else begin
            busy_q <= busy;
            if (busy && !busy_q) begin
                op_q <= op_is_erase;
            end
        end
    end

    // Falling edge of busy: registered high, input low.
    always_comb begin
        busy_fall    = busy_q && !busy;
        end_is_erase = op_q;
    end
endmodule

// File: rtl/flag_status_bank.sv
// Sticky status flags with write-one-to-clear.
// A set has priority over a clear in the same cycle.
module flag_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    logic [W-1:0] flag_q;

    // One sticky flop per flag; new events win over software clears.
    generate
        for (genvar i = 0; i < W; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    flag_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    // Drive the output from the flag registers.
    always_comb flags = flag_q;
endmodule

// File: rtl/held_event_gate.sv
// Defers interrupt qualification of events that arrive while busy is high.
// An event with busy low qualifies at once. An event during busy is kept pending
// and qualifies on the falling cycle, gated by the enable value at that time.
module held_event_gate #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         busy_fall,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] en,
    output logic [N-1:0] hit
);
    logic [N-1:0] pend_q;

    // Keep a pending bit per source until busy falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~{N{busy_fall}}) | (ev & {N{busy}});
        end
    end

    // Immediate hits when idle, released hits on the falling cycle.
    always_comb begin
        hit = (ev & ~{N{busy}} & en) | (pend_q & {N{busy_fall}} & en);
    end
endmodule

// File: rtl/irq_merge.sv
// Merges all qualified sources into one registered request pulse.
// Assumes each hit lasts one cycle, so the output lasts one cycle per event cycle.
module irq_merge #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    output logic         irq
);
    logic irq_q;

    // Register the OR of all qualified sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |hit;
        end
    end

    // Drive the request output from its register.
    always_comb irq = irq_q;
endmodule

// File: rtl/flash_irq_ctrl.sv
// Flash status and interrupt controller top.
// Collects flash events into sticky flags, holds the enable mask and raises one
// pulse-style interrupt request. Address 0: status (W1C); address 1: enable mask.
// Assumes DATA_W >= FLAG_W and event inputs are single-cycle pulses.
module flash_irq_ctrl
    import flash_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              op_is_erase,
    input  logic              ev_abort,
    input  logic              ev_verify,
    input  logic              ev_prot,
    input  logic              ev_seq,
    input  logic              ev_sbe,
    input  logic              ev_dbe,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic                busy_fall;
    logic                end_is_erase;
    logic [FLAG_W-1:0]   set_vec;
    logic [FLAG_W-1:0]   clr_vec;
    logic [FLAG_W-1:0]   flag_q;
    logic [NUM_SRC-1:0]  en_q;
    logic [NUM_SRC-1:0]  hit_vec;
    logic [NUM_HELD-1:0] held_ev;
    logic [NUM_HELD-1:0] held_en;
    logic [NUM_HELD-1:0] held_hit;

    busy_phase_tracker u_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .op_is_erase  (op_is_erase),
        .busy_fall    (busy_fall),
        .end_is_erase (end_is_erase)
    );

    // Map events onto status flag positions.
    always_comb begin
        set_vec             = '0;
        set_vec[FLG_PROG]   = busy_fall && !end_is_erase;
        set_vec[FLG_ERASE]  = busy_fall && end_is_erase;
        set_vec[FLG_ABORT]  = ev_abort;
        set_vec[FLG_VERIFY] = ev_verify;
        set_vec[FLG_PROT]   = ev_prot;
        set_vec[FLG_SEQ]    = ev_seq;
        set_vec[FLG_SBE]    = ev_sbe;
        set_vec[FLG_DBE]    = ev_dbe;
    end

    // Software write-one-to-clear at address 0.
    always_comb clr_vec = (wr_en && !wr_addr) ? wr_data[FLAG_W-1:0] : '0;

    flag_status_bank #(.W(FLAG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flag_q)
    );

    // Enable mask register at address 1; all sources off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && wr_addr) begin
            en_q <= wr_data[NUM_SRC-1:0];
        end
    end

    // Route the two deferrable sources through the held gate.
    always_comb begin
        held_ev = {ev_verify, ev_abort};
        held_en = {en_q[SRC_VERIFY], en_q[SRC_ABORT]};
    end

    held_event_gate #(.N(NUM_HELD)) u_held (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .busy_fall (busy_fall),
        .ev        (held_ev),
        .en        (held_en),
        .hit       (held_hit)
    );

    // Qualify every source with its enable bit.
    always_comb begin
        hit_vec             = '0;
        hit_vec[SRC_DONE]   = busy_fall && en_q[SRC_DONE];
        hit_vec[SRC_ABORT]  = held_hit[0];
        hit_vec[SRC_VERIFY] = held_hit[1];
        hit_vec[SRC_PROT]   = ev_prot && en_q[SRC_PROT];
        hit_vec[SRC_SEQ]    = ev_seq && en_q[SRC_SEQ];
        hit_vec[SRC_SBE]    = ev_sbe && en_q[SRC_SBE];
        hit_vec[SRC_DBE]    = ev_dbe && en_q[SRC_DBE];
    end

    irq_merge #(.N(NUM_SRC)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit_vec),
        .irq   (irq)
    );

    // Read multiplexer for the two registers.
    always_comb begin
        rd_data = '0;
        if (!rd_addr) begin
            rd_data[FLAG_W-1:0] = flag_q;
        end else begin
            rd_data[NUM_SRC-1:0] = en_q;
        end
    end
endmodule

// File: rtl/flash_irq_ctrl_chk.sv
// Property checker for flash_irq_ctrl, attached by bind.
// Observes ports plus the flag register; keeps its own delayed busy copy.
module flash_irq_ctrl_chk
    import flash_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ev_abort,
    input logic              ev_verify,
    input logic              ev_prot,
    input logic              ev_seq,
    input logic              ev_sbe,
    input logic              ev_dbe,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [FLAG_W-1:0] flags,
    input logic              irq
);
    logic              busy_d;
    logic              src_any;
    logic [FLAG_W-1:0] clr_mask;

    // Checker-side copy of the previous busy level.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_d <= 1'b0;
        else        busy_d <= busy;
    end

    // Anything in this cycle that may legally lead to a request next cycle.
    always_comb begin
        src_any  = ev_prot || ev_seq || ev_sbe || ev_dbe ||
                   ((ev_abort || ev_verify) && !busy) || (busy_d && !busy);
        clr_mask = (wr_en && !wr_addr) ? wr_data[FLAG_W-1:0] : '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0 && !irq));

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags & ~$past(clr_mask)) == '0));

    // R5
    clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_abort && wr_en && !wr_addr && wr_data[FLG_ABORT]) |=> flags[FLG_ABORT]);

    // R3
    end_busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_d && !busy) |=> (flags[FLG_PROG] || flags[FLG_ERASE]));

    // R7
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(src_any));

    // R10
    enable_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && !src_any) |=> !irq);
endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .ev_abort  (ev_abort),
    .ev_verify (ev_verify),
    .ev_prot   (ev_prot),
    .ev_seq    (ev_seq),
    .ev_sbe    (ev_sbe),
    .ev_dbe    (ev_dbe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flags     (flag_q),
    .irq       (irq)
);

// File: tb/flash_irq_ctrl_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a reference model written from the requirements.
module flash_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0, op_is_erase = 1'b0;
    logic       ev_abort = 1'b0, ev_verify = 1'b0, ev_prot = 1'b0;
    logic       ev_seq = 1'b0, ev_sbe = 1'b0, ev_dbe = 1'b0;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [7:0] m_flags = '0;
    logic [6:0] m_en = '0;
    logic [1:0] m_pend = '0;
    logic       m_busy_q = 1'b0, m_op = 1'b0, m_irq = 1'b0;

    always #2 clk = ~clk;

    flash_irq_ctrl u_flash_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_is_erase(op_is_erase),
        .ev_abort(ev_abort), .ev_verify(ev_verify), .ev_prot(ev_prot),
        .ev_seq(ev_seq), .ev_sbe(ev_sbe), .ev_dbe(ev_dbe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic a);
        return a ? {1'b0, m_en} : m_flags;
    endfunction

    // One clock: predict next state from current inputs, advance, compare.
    task automatic step();
        logic       fall;
        logic [7:0] set_v, clr_v;
        logic [6:0] hit;
        fall  = m_busy_q && !busy;
        set_v = {ev_dbe, ev_sbe, ev_seq, ev_prot, ev_verify, ev_abort,
                 fall && m_op, fall && !m_op};
        clr_v = (wr_en && !wr_addr) ? wr_data : 8'h00;
        hit[0] = fall && m_en[0];
        hit[1] = m_en[1] && ((ev_abort && !busy) || (m_pend[0] && fall));
        hit[2] = m_en[2] && ((ev_verify && !busy) || (m_pend[1] && fall));
        hit[3] = ev_prot && m_en[3];
        hit[4] = ev_seq && m_en[4];
        hit[5] = ev_sbe && m_en[5];
        hit[6] = ev_dbe && m_en[6];
        @(posedge clk);
        m_flags = (m_flags & ~clr_v) | set_v;
        m_pend  = (m_pend & ~{2{fall}}) | ({ev_verify, ev_abort} & {2{busy}});
        if (wr_en && wr_addr) m_en = wr_data[6:0];
        if (busy && !m_busy_q) m_op = op_is_erase;
        m_busy_q = busy;
        m_irq = |hit;
        #1;
        chk("R6 irq vs model", {7'b0, irq}, {7'b0, m_irq});
        chk("R11 read vs model", rd_data, exp_read(rd_addr));
        {ev_abort, ev_verify, ev_prot, ev_seq, ev_sbe, ev_dbe, wr_en} = '0;
    endtask

    task automatic rd(input logic a, input string tag, input logic [7:0] exp);
        rd_addr = a;
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        rd(1'b0, "R1 flags after reset", 8'h00);
        rd(1'b1, "R1 enables after reset", 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);

        // R6: disabled source sets flag, no pulse; R2 bit 4
        ev_prot = 1'b1; step();
        chk("R6 disabled no irq", {7'b0, irq}, 8'h00);
        rd(1'b0, "R2 protection flag bit4", 8'h10);

        // R10: enabling with flag already set gives no pulse
        wr(1'b1, 8'h7F); step();
        chk("R10 enable write quiet", {7'b0, irq}, 8'h00);
        step();
        chk("R10 still quiet", {7'b0, irq}, 8'h00);
        rd(1'b1, "R11 enable read bit7 zero", 8'h7F);

        // R8: repeat event with flag set fires again
        ev_prot = 1'b1; step();
        chk("R8 repeat event pulses", {7'b0, irq}, 8'h01);
        step();
        chk("R6 single cycle pulse", {7'b0, irq}, 8'h00);

        // R4: zero write keeps flag, one clears it
        rd_addr = 1'b0;
        wr(1'b0, 8'h00); step();
        rd(1'b0, "R4 zero write keeps", 8'h10);
        wr(1'b0, 8'h10); step();
        rd(1'b0, "R4 one write clears", 8'h00);

        // R5: clear racing abort event (busy low, immediate pulse R7)
        ev_abort = 1'b1; wr(1'b0, 8'h04); step();
        rd(1'b0, "R5 set wins over clear", 8'h04);
        chk("R7 abort idle fires at once", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'hFF); step();

        // R7 + R3: verify during erase is deferred to busy fall
        busy = 1'b1; op_is_erase = 1'b1; step();
        ev_verify = 1'b1; step();
        chk("R7 verify held during busy", {7'b0, irq}, 8'h00);
        repeat (3) begin
            step();
            chk("R7 still held", {7'b0, irq}, 8'h00);
        end
        busy = 1'b0; step();
        chk("R7 released on fall", {7'b0, irq}, 8'h01);
        rd(1'b0, "R3 erase done and verify flags", 8'h0A);
        step();
        chk("R9 single pulse on fall", {7'b0, irq}, 8'h00);

        // R3: program operation ends with bit 0
        wr(1'b0, 8'hFF); step();
        busy = 1'b1; op_is_erase = 1'b0; step();
        op_is_erase = 1'b1; step();
        busy = 1'b0; step();
        rd(1'b0, "R3 program done flag", 8'h01);

        // R9: simultaneous sources -> one pulse
        ev_seq = 1'b1; ev_sbe = 1'b1; ev_dbe = 1'b1; step();
        chk("R9 merged pulse", {7'b0, irq}, 8'h01);
        step();
        chk("R9 pulse ends", {7'b0, irq}, 8'h00);

        // R7: abort during busy, mask cleared before fall -> no pulse
        busy = 1'b1; step();
        ev_abort = 1'b1; step();
        wr(1'b1, 8'h00); step();
        busy = 1'b0; step();
        chk("R7 disabled at fall suppressed", {7'b0, irq}, 8'h00);
        step();

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 10 == 0) busy = ~busy;
            op_is_erase = 1'($urandom);
            ev_abort  = ($urandom % 9 == 0);
            ev_verify = ($urandom % 9 == 0);
            ev_prot   = ($urandom % 12 == 0);
            ev_seq    = ($urandom % 12 == 0);
            ev_sbe    = ($urandom % 12 == 0);
            ev_dbe    = ($urandom % 12 == 0);
            if ($urandom % 6 == 0) wr(1'($urandom), 8'($urandom));
            rd_addr = 1'($urandom);
            step();
        end
        finish_run();
    end
endmodule